// File: doc/BRIEF.md
# Low-Power Mode and Wake-up Controller

This block manages the clocking of a small microcontroller. Software writes an 8-bit mode register that carries three live fields: the system-clock choice, the fast-clock generator enable, and the halt-depth choice. While the CPU runs, the block turns these fields into enables for a slow 32768 Hz source and a fast 3.58 MHz source, and into a system-clock select. A halt strobe from the CPU stops the system clock. The halt-depth field then decides whether the slow source keeps running (Sleep) or is stopped too (Idle).

While halted, the block watches three kinds of wake source: a reset request, interrupt requests, and port pins that have their wake mask bit set. An interrupt whose request flag was already set when the halt began cannot wake the device. On a wake-up the block clears the fast-clock fields of the register, so the device comes back in Green mode. It then holds the CPU off for a fixed number of slow-clock ticks. After that it releases the CPU and, when the waking interrupt was enabled and the stack had room, raises a one-cycle interrupt-vector request. Entering halt sets the power-down flag, clears the time-out flag and pulses a watchdog clear.

Top module: `pwr_mode_ctl`

## Requirements
- R1: The register keeps the written value in bits 7 (fast system clock select), 6 (halt depth: 1 = Idle, 0 = Sleep) and 5 (fast generator enable), and always reads bits 4..0 as zero.
- R2: While running, the slow enable is 1, the fast enable follows bit 5, and the system-clock select is 1 only when bits 7 and 5 are both 1.
- R3: While halted, the fast enable and the clock select are 0, and the slow enable is the inverse of bit 6.
- R4: A halt strobe while running, with no reset request, stops the CPU on the next cycle. It also sets the power-down flag, clears the time-out flag and pulses the watchdog clear for one cycle.
- R5: While halted, a port pin wakes the device only if its mask bit is 1.
- R6: After a wake, the CPU stays stopped for DELAY_CYCLES slow ticks (default 1024), counting only cycles with the slow tick high.
- R7: A wake clears bits 7 and 5 and keeps bit 6. During the delay only the slow clock runs, and it is the system clock.
- R8: When the CPU resumes, the interrupt-vector request pulses for one cycle only if a waking interrupt was enabled and the stack was not full. Otherwise it stays 0.
- R9: An interrupt whose request was high when the halt was entered does not wake the device.
- R10: A halt strobe during the wake delay is ignored, and the CPU runs after the delay.
- R11: Register writes are ignored while the CPU is stopped.
- R12: A reset request clears the whole register to 0x00 in any state, and while halted it also starts the wake delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous block reset |
| reg_wr | input | 1 | Mode register write strobe |
| reg_wdata | input | 8 | Mode register write data |
| reg_rdata | output | 8 | Mode register read data |
| halt_req | input | 1 | Halt strobe from the CPU |
| wake_rst | input | 1 | Reset-condition wake request |
| irq_req | input | N_IRQ | Interrupt request flags |
| irq_en | input | N_IRQ | Interrupt enables |
| stack_full | input | 1 | Call stack has no free entry |
| port_wake | input | N_PW | Port pin levels |
| port_wake_mask | input | N_PW | Per-pin wake enables |
| slow_tick | input | 1 | One-cycle strobe per slow-clock period |
| slow_clk_en | output | 1 | Enable for the 32768 Hz source |
| fast_clk_en | output | 1 | Enable for the 3.58 MHz generator |
| sys_clk_sel | output | 1 | 1 = fast system clock, 0 = slow |
| cpu_run | output | 1 | CPU execution gate |
| irq_vec_req | output | 1 | Interrupt response request after wake |
| pdf_flag | output | 1 | Power-down flag |
| to_flag | output | 1 | Time-out flag |
| wdt_clr | output | 1 | Watchdog counter/prescaler clear pulse |

## Verification
The assertions check every cycle that the clock enables and the select match the register in the running and halted states, and that the select never picks a stopped fast clock. They also check the halt-entry flags, that a halt strobe cannot break into the wake delay, that writes are locked out while stopped, and the exact delay length, measured by a counter of the checker's own. The bench's scenarios are needed for the rest. These cover which pins and interrupts actually wake the device, the masking of interrupts already pending at halt, the vector request under enabled, disabled and stack-full conditions, the delay at a reduced slow-tick rate, and the register clearing on a reset request.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

   localparam int REG_W     = 8;
   localparam int SEL_BIT   = 7;
   localparam int DEPTH_BIT = 6;
   localparam int GEN_BIT   = 5;

   typedef enum logic [1:0] {
      PM_RUN  = 2'd0,
      PM_HALT = 2'd1,
      PM_WAKE = 2'd2
   } pm_state_e;

   typedef struct packed {
      logic fast_sel;
      logic deep_halt;
      logic gen_en;
   } pm_mode_t;

endpackage

// File: rtl/pmc_mode_reg.sv
module pmc_mode_reg
   import pmc_pkg::*;
#(
   parameter int W = REG_W
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_en,
   input  logic [W-1:0] wdata,
   input  logic         clr_all,
   input  logic         clr_fast,
   output pm_mode_t     mode,
   output logic [W-1:0] rdata
);

   if (W <= SEL_BIT) begin : g_bad_width
      $error("pmc_mode_reg: W must exceed the highest field bit");
   end

   pm_mode_t mode_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= '0;
      end else if (clr_all) begin
         mode_q <= '0;
      end else if (clr_fast) begin
         mode_q.fast_sel <= 1'b0;
         mode_q.gen_en   <= 1'b0;
      end else if (wr_en) begin
         mode_q.fast_sel  <= wdata[SEL_BIT];
         mode_q.deep_halt <= wdata[DEPTH_BIT];
         mode_q.gen_en    <= wdata[GEN_BIT];
      end
   end

   for (genvar b = 0; b < W; b++) begin : g_rd
      if (b == SEL_BIT) begin : g_sel
         assign rdata[b] = mode_q.fast_sel;
      end else if (b == DEPTH_BIT) begin : g_dep
         assign rdata[b] = mode_q.deep_halt;
      end else if (b == GEN_BIT) begin : g_gen
         assign rdata[b] = mode_q.gen_en;
      end else begin : g_zero
         assign rdata[b] = 1'b0;
      end
   end

   logic unused_wbits;
   assign unused_wbits = ^wdata;
   assign mode = mode_q;

endmodule

// File: rtl/pmc_wake_src.sv
module pmc_wake_src #(
   parameter int N_IRQ     = 4,
   parameter int N_PW      = 8,
   parameter bit PORT_EDGE = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             halt_enter,
   input  logic             wake_rst,
   input  logic [N_IRQ-1:0] irq_req,
   input  logic [N_IRQ-1:0] irq_en,
   input  logic             stack_full,
   input  logic [N_PW-1:0]  port_wake,
   input  logic [N_PW-1:0]  port_mask,
   output logic             wake_any,
   output logic             svc_irq
);

   if (N_IRQ < 1) begin : g_bad_irq
      $error("pmc_wake_src: N_IRQ must be at least 1");
   end
   if (N_PW < 1) begin : g_bad_pw
      $error("pmc_wake_src: N_PW must be at least 1");
   end

   logic [N_IRQ-1:0] stale_q;
   logic [N_IRQ-1:0] live_irq;
   logic [N_PW-1:0]  pin_hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stale_q <= '0;
      end else if (halt_enter) begin
         stale_q <= irq_req;
      end
   end

   for (genvar i = 0; i < N_IRQ; i++) begin : g_irq
      assign live_irq[i] = irq_req[i] & ~stale_q[i];
   end

   if (PORT_EDGE) begin : g_pin_edge
      logic [N_PW-1:0] pin_prev_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) pin_prev_q <= '0;
         else        pin_prev_q <= port_wake;
      end
      assign pin_hit = port_wake & ~pin_prev_q & port_mask;
   end else begin : g_pin_level
      assign pin_hit = port_wake & port_mask;
   end

   assign wake_any = wake_rst | (|live_irq) | (|pin_hit);
   assign svc_irq  = (|(live_irq & irq_en)) & ~stack_full & ~wake_rst;

endmodule

// File: rtl/pmc_wake_seq.sv
module pmc_wake_seq
   import pmc_pkg::*;
#(
   parameter int DELAY_CYCLES = 1024
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      halt_req,
   input  logic      wake_rst,
   input  logic      wake_any,
   input  logic      svc_irq,
   input  logic      slow_tick,
   output pm_state_e st,
   output logic      halt_enter,
   output logic      wake_enter,
   output logic      wdt_clr,
   output logic      pdf_flag,
   output logic      to_flag,
   output logic      irq_vec_req
);

   localparam int CNT_W = (DELAY_CYCLES > 2) ? $clog2(DELAY_CYCLES) : 1;
   localparam logic [CNT_W-1:0] LAST = CNT_W'(DELAY_CYCLES - 1);

   if (DELAY_CYCLES < 2) begin : g_bad_delay
      $error("pmc_wake_seq: DELAY_CYCLES must be at least 2");
   end

   pm_state_e        st_q;
   logic [CNT_W-1:0] cnt_q;
   logic             svc_q;

   assign halt_enter = (st_q == PM_RUN) && halt_req && !wake_rst;
   assign wake_enter = (st_q == PM_HALT) && wake_any;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q        <= PM_RUN;
         cnt_q       <= '0;
         svc_q       <= 1'b0;
         wdt_clr     <= 1'b0;
         pdf_flag    <= 1'b0;
         to_flag     <= 1'b0;
         irq_vec_req <= 1'b0;
      end else begin
         wdt_clr     <= halt_enter;
         irq_vec_req <= 1'b0;
         if (halt_enter) begin
            pdf_flag <= 1'b1;
            to_flag  <= 1'b0;
         end
         case (st_q)
            PM_RUN: begin
               if (halt_enter) st_q <= PM_HALT;
            end
            PM_HALT: begin
               if (wake_enter) begin
                  st_q  <= PM_WAKE;
                  cnt_q <= '0;
                  svc_q <= svc_irq;
               end
            end
            PM_WAKE: begin
               if (slow_tick) begin
                  if (cnt_q == LAST) begin
                     st_q        <= PM_RUN;
                     irq_vec_req <= svc_q;
                  end else begin
                     cnt_q <= cnt_q + 1'b1;
                  end
               end
            end
            default: st_q <= PM_RUN;
         endcase
      end
   end

   assign st = st_q;

endmodule

// File: rtl/pmc_clk_decode.sv
module pmc_clk_decode
   import pmc_pkg::*;
(
   input  pm_state_e st,
   input  pm_mode_t  mode,
   output logic      slow_clk_en,
   output logic      fast_clk_en,
   output logic      sys_clk_sel,
   output logic      cpu_run
);

   always_comb begin
      slow_clk_en = 1'b0;
      fast_clk_en = 1'b0;
      sys_clk_sel = 1'b0;
      cpu_run     = 1'b0;
      case (st)
         PM_RUN: begin
            slow_clk_en = 1'b1;
            fast_clk_en = mode.gen_en;
            sys_clk_sel = mode.fast_sel & mode.gen_en;
            cpu_run     = 1'b1;
         end
         PM_HALT: begin
            slow_clk_en = ~mode.deep_halt;
         end
         PM_WAKE: begin
            slow_clk_en = 1'b1;
         end
         default: begin
            slow_clk_en = 1'b0;
         end
      endcase
   end

endmodule

// File: rtl/pwr_mode_ctl.sv
module pwr_mode_ctl
   import pmc_pkg::*;
#(
   parameter int DELAY_CYCLES = 1024,
   parameter int N_IRQ        = 4,
   parameter int N_PW         = 8,
   parameter bit PORT_EDGE    = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             reg_wr,
   input  logic [7:0]       reg_wdata,
   output logic [7:0]       reg_rdata,
   input  logic             halt_req,
   input  logic             wake_rst,
   input  logic [N_IRQ-1:0] irq_req,
   input  logic [N_IRQ-1:0] irq_en,
   input  logic             stack_full,
   input  logic [N_PW-1:0]  port_wake,
   input  logic [N_PW-1:0]  port_wake_mask,
   input  logic             slow_tick,
   output logic             slow_clk_en,
   output logic             fast_clk_en,
   output logic             sys_clk_sel,
   output logic             cpu_run,
   output logic             irq_vec_req,
   output logic             pdf_flag,
   output logic             to_flag,
   output logic             wdt_clr
);

   pm_state_e st;
   pm_mode_t  mode;
   logic      halt_enter;
   logic      wake_enter;
   logic      wake_any;
   logic      svc_irq;

   pmc_mode_reg #(.W(REG_W)) u_reg (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (reg_wr & cpu_run),
      .wdata    (reg_wdata),
      .clr_all  (wake_rst),
      .clr_fast (wake_enter),
      .mode     (mode),
      .rdata    (reg_rdata)
   );

   pmc_wake_src #(
      .N_IRQ     (N_IRQ),
      .N_PW      (N_PW),
      .PORT_EDGE (PORT_EDGE)
   ) u_src (
      .clk        (clk),
      .rst_n      (rst_n),
      .halt_enter (halt_enter),
      .wake_rst   (wake_rst),
      .irq_req    (irq_req),
      .irq_en     (irq_en),
      .stack_full (stack_full),
      .port_wake  (port_wake),
      .port_mask  (port_wake_mask),
      .wake_any   (wake_any),
      .svc_irq    (svc_irq)
   );

   pmc_wake_seq #(.DELAY_CYCLES(DELAY_CYCLES)) u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .halt_req    (halt_req),
      .wake_rst    (wake_rst),
      .wake_any    (wake_any),
      .svc_irq     (svc_irq),
      .slow_tick   (slow_tick),
      .st          (st),
      .halt_enter  (halt_enter),
      .wake_enter  (wake_enter),
      .wdt_clr     (wdt_clr),
      .pdf_flag    (pdf_flag),
      .to_flag     (to_flag),
      .irq_vec_req (irq_vec_req)
   );

   pmc_clk_decode u_dec (
      .st          (st),
      .mode        (mode),
      .slow_clk_en (slow_clk_en),
      .fast_clk_en (fast_clk_en),
      .sys_clk_sel (sys_clk_sel),
      .cpu_run     (cpu_run)
   );

endmodule

// File: rtl/pmc_chk.sv
module pmc_chk
   import pmc_pkg::*;
#(
   parameter int DELAY_CYCLES = 1024
) (
   input logic       clk,
   input logic       rst_n,
   input pm_state_e  st,
   input logic       reg_wr,
   input logic [7:0] reg_wdata,
   input logic [7:0] reg_rdata,
   input logic       halt_req,
   input logic       wake_rst,
   input logic       slow_tick,
   input logic       slow_clk_en,
   input logic       fast_clk_en,
   input logic       sys_clk_sel,
   input logic       cpu_run,
   input logic       irq_vec_req,
   input logic       pdf_flag,
   input logic       to_flag,
   input logic       wdt_clr
);

   int unsigned ticks_seen;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                            ticks_seen <= 0;
      else if (st != PM_WAKE)                ticks_seen <= 0;
      else if (slow_tick)                    ticks_seen <= ticks_seen + 1;
   end

   p_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && cpu_run && !wake_rst) |=> (reg_rdata[7:5] == $past(reg_wdata[7:5])));

   p_run_decode_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (st == PM_RUN) |-> (slow_clk_en && cpu_run && fast_clk_en == reg_rdata[5]
                          && sys_clk_sel == (reg_rdata[7] & reg_rdata[5])));

   p_halt_decode_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (st == PM_HALT) |-> (!fast_clk_en && !sys_clk_sel && !cpu_run
                           && slow_clk_en == !reg_rdata[6]));

   p_halt_entry_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_run && halt_req && !wake_rst) |=> (!cpu_run && pdf_flag && !to_flag && wdt_clr));

   p_delay_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (st == PM_WAKE && !(slow_tick && ticks_seen == DELAY_CYCLES - 1)) |=> (st == PM_WAKE));

   p_delay_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (st == PM_WAKE && slow_tick && ticks_seen == DELAY_CYCLES - 1) |=> cpu_run);

   p_green_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (st == PM_WAKE) |-> (slow_clk_en && !fast_clk_en && !sys_clk_sel
                           && reg_rdata[7] == 1'b0 && reg_rdata[5] == 1'b0));

   p_vec_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
      irq_vec_req |-> (cpu_run && $past(st) == PM_WAKE));

   p_no_rehalt_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (st == PM_WAKE) |=> (st != PM_HALT));

   p_locked_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (!cpu_run && st == PM_HALT && !halt_req && !wake_rst && $past(st) == PM_HALT)
      |=> (st != PM_HALT || $stable(reg_rdata)));

   p_rst_clear_r12: assert property (@(posedge clk) disable iff (!rst_n)
      wake_rst |=> (reg_rdata == 8'h00));

   p_sel_safe_r2: assert property (@(posedge clk) disable iff (!rst_n)
      sys_clk_sel |-> fast_clk_en);

endmodule

bind pwr_mode_ctl pmc_chk #(.DELAY_CYCLES(DELAY_CYCLES)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .st          (st),
   .reg_wr      (reg_wr),
   .reg_wdata   (reg_wdata),
   .reg_rdata   (reg_rdata),
   .halt_req    (halt_req),
   .wake_rst    (wake_rst),
   .slow_tick   (slow_tick),
   .slow_clk_en (slow_clk_en),
   .fast_clk_en (fast_clk_en),
   .sys_clk_sel (sys_clk_sel),
   .cpu_run     (cpu_run),
   .irq_vec_req (irq_vec_req),
   .pdf_flag    (pdf_flag),
   .to_flag     (to_flag),
   .wdt_clr     (wdt_clr)
);

// File: tb/pwr_mode_ctl_tb_top.sv
`timescale 1ns/1ps
module pwr_mode_ctl_tb_top;

   localparam int DLY = 1024;
   localparam int NI  = 4;
   localparam int NP  = 8;

   // vector: write data, expected fast enable, expected clock select
   localparam int NV = 7;
   localparam logic [9:0] VEC [NV] = '{
      {8'h00, 1'b0, 1'b0},
      {8'hE0, 1'b1, 1'b1},
      {8'hA0, 1'b1, 1'b1},
      {8'h80, 1'b0, 1'b0},
      {8'h20, 1'b1, 1'b0},
      {8'hFF, 1'b1, 1'b1},
      {8'h5F, 1'b0, 1'b0}
   };

   logic          clk = 1'b0;
   logic          rst_n;
   logic          reg_wr;
   logic [7:0]    reg_wdata;
   logic [7:0]    reg_rdata;
   logic          halt_req;
   logic          wake_rst;
   logic [NI-1:0] irq_req;
   logic [NI-1:0] irq_en;
   logic          stack_full;
   logic [NP-1:0] port_wake;
   logic [NP-1:0] port_wake_mask;
   logic          slow_tick;
   logic          slow_clk_en, fast_clk_en, sys_clk_sel, cpu_run;
   logic          irq_vec_req, pdf_flag, to_flag, wdt_clr;

   int n_chk = 0;
   int n_bad = 0;
   logic wdt_seen;

   always #2.5 clk = ~clk;

   pwr_mode_ctl #(.DELAY_CYCLES(DLY), .N_IRQ(NI), .N_PW(NP)) dut_i (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .halt_req(halt_req), .wake_rst(wake_rst),
      .irq_req(irq_req), .irq_en(irq_en), .stack_full(stack_full),
      .port_wake(port_wake), .port_wake_mask(port_wake_mask),
      .slow_tick(slow_tick), .slow_clk_en(slow_clk_en),
      .fast_clk_en(fast_clk_en), .sys_clk_sel(sys_clk_sel),
      .cpu_run(cpu_run), .irq_vec_req(irq_vec_req), .pdf_flag(pdf_flag),
      .to_flag(to_flag), .wdt_clr(wdt_clr)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] v);
      @(negedge clk); reg_wr = 1'b1; reg_wdata = v;
      @(negedge clk); reg_wr = 1'b0;
   endtask

   task automatic do_halt();
      @(negedge clk); halt_req = 1'b1;
      @(negedge clk); wdt_seen = wdt_clr; halt_req = 1'b0;
   endtask

   // counts negedges until the CPU runs; pulses halt at step 5; half_rate toggles tick
   task automatic wait_run(input bit half_rate, output int n);
      n = 0;
      while (!cpu_run && n < 5000) begin
         @(negedge clk);
         n++;
         halt_req = (n == 5);
         if (half_rate) slow_tick = ~slow_tick;
      end
      halt_req  = 1'b0;
      slow_tick = 1'b1;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      int n;
      rst_n = 1'b0; reg_wr = 1'b0; reg_wdata = '0; halt_req = 1'b0;
      wake_rst = 1'b0; irq_req = '0; irq_en = '0; stack_full = 1'b0;
      port_wake = '0; port_wake_mask = 8'h04; slow_tick = 1'b1;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // reset state
      check("R1 reset rdata", reg_rdata, 8'h00);
      check("R2 reset run", cpu_run, 1);
      check("R2 reset slow", slow_clk_en, 1);
      check("R2 reset fast", fast_clk_en, 0);
      check("R2 reset sel", sys_clk_sel, 0);
      check("R4 reset pdf", pdf_flag, 0);
      check("R4 reset to", to_flag, 0);

      // running-mode decode table
      for (int i = 0; i < NV; i++) begin
         wr(VEC[i][9:2]);
         check("R1 readback", reg_rdata, VEC[i][9:2] & 8'hE0);
         check("R2 fast en", fast_clk_en, VEC[i][1]);
         check("R2 clk sel", sys_clk_sel, VEC[i][0]);
         check("R2 slow en", slow_clk_en, 1);
      end

      // Idle halt, masked pin, write lockout, unmasked pin wake, halt during delay
      wr(8'hE0);
      do_halt();
      check("R4 cpu stopped", cpu_run, 0);
      check("R4 pdf set", pdf_flag, 1);
      check("R4 to clear", to_flag, 0);
      check("R4 wdt clear", wdt_seen, 1);
      check("R3 idle slow off", slow_clk_en, 0);
      check("R3 fast off", fast_clk_en, 0);
      check("R3 sel slow", sys_clk_sel, 0);
      @(negedge clk); reg_wr = 1'b1; reg_wdata = 8'h00;
      @(negedge clk); reg_wr = 1'b0;
      check("R11 write ignored", reg_rdata, 8'hE0);
      port_wake = 8'h02;
      repeat (3) @(negedge clk);
      check("R5 masked pin no wake", cpu_run, 0);
      check("R5 masked pin still halted", slow_clk_en, 0);
      port_wake = 8'h06;
      @(negedge clk); port_wake = '0;
      check("R7 green slow on", slow_clk_en, 1);
      check("R7 green fast off", fast_clk_en, 0);
      check("R7 fields cleared", reg_rdata, 8'h40);
      wait_run(1'b0, n);
      check("R6 delay length", n, DLY);
      check("R8 no vector on pin wake", irq_vec_req, 0);
      @(negedge clk);
      check("R10 halt in delay ignored", cpu_run, 1);

      // Sleep halt with a stale interrupt, then a fresh enabled one, half-rate tick
      wr(8'hA0);
      irq_en = 4'hF; irq_req = 4'h1;
      do_halt();
      check("R3 sleep slow on", slow_clk_en, 1);
      repeat (4) @(negedge clk);
      check("R9 stale irq no wake", cpu_run, 0);
      check("R9 stale irq halted", slow_clk_en, 1);
      irq_req = 4'h3;
      @(negedge clk); irq_req = '0;
      check("R7 sleep fields cleared", reg_rdata, 8'h00);
      wait_run(1'b1, n);
      check("R6 half-rate delay", (n == 2*DLY || n == 2*DLY-1), 1);
      check("R8 vector when enabled", irq_vec_req, 1);
      @(negedge clk);
      check("R8 vector single pulse", irq_vec_req, 0);

      // stack full: wake without vector
      stack_full = 1'b1;
      do_halt();
      irq_req = 4'h4;
      @(negedge clk); irq_req = '0;
      wait_run(1'b0, n);
      check("R8 stack full no vector", irq_vec_req, 0);
      stack_full = 1'b0;

      // disabled interrupt: wake without vector
      irq_en = 4'h0;
      do_halt();
      irq_req = 4'h2;
      @(negedge clk); irq_req = '0;
      check("R5 disabled irq wakes", slow_clk_en, 1);
      wait_run(1'b0, n);
      check("R8 disabled no vector", irq_vec_req, 0);
      check("R6 disabled delay", n, DLY);

      // reset request while halted and while running
      wr(8'hE0);
      do_halt();
      wake_rst = 1'b1;
      @(negedge clk); wake_rst = 1'b0;
      check("R12 reset wake clears", reg_rdata, 8'h00);
      wait_run(1'b0, n);
      check("R12 reset wake delay", n, DLY);
      check("R12 no vector", irq_vec_req, 0);
      wr(8'hA0);
      @(negedge clk); wake_rst = 1'b1;
      @(negedge clk); wake_rst = 1'b0;
      check("R12 reset in run clears", reg_rdata, 8'h00);
      check("R12 cpu keeps running", cpu_run, 1);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule